// File: doc/BRIEF.md
# Multidrop 9-bit Address Filter

This block sits on the receive side of a UART that runs 9-bit multidrop framing. In this framing many slave nodes share one bus with a single master. Each received character carries eight data bits and a ninth mark bit. A mark bit of 1 tags the character as an address, and a mark bit of 0 tags it as data. The filter compares each address character with the node's own programmable 8-bit address. It then decides what happens to the data characters that follow.

In automatic mode the hardware does the filtering. A matching address opens the data path. A non-matching address closes it. Address characters never reach the output stream. In manual mode every character is passed on, and address characters carry a flag so that software can make the decision. In both modes a one-cycle pulse marks every address character, and a level shows whether the most recent address matched.

The filter starts closed after reset. Serial bit timing, baud generation and buffering belong to neighbouring blocks. All outputs are registered and appear one clock after the accepted input strobe.

Top module: `mdf_top`

## Requirements
- R1: After reset, outValid, addrSeen and addrMatch are all 0, and the filter is closed.
- R2: A character with rxChar[8]=1 is an address character. One with rxChar[8]=0 is a data character, and a data character never changes addrMatch, whatever its low 8 bits are.
- R3: Every address character presented with rxValid produces addrSeen=1 for exactly the following cycle, whether it matches or not. Otherwise addrSeen is 0.
- R4: On an address character, addrMatch takes the value (rxChar[7:0]==nodeAddr) in the following cycle, in either mode. Without an address character, addrMatch holds its value.
- R5: In automatic mode (autoMode=1), a data character received while addrMatch=1 is output one cycle later with outValid=1, outData=rxChar[7:0] and outIsAddr=0.
- R6: In automatic mode, a data character received while addrMatch=0 produces no output. This includes data that arrives before any address after reset.
- R7: In automatic mode, an address character never produces outValid.
- R8: In manual mode (autoMode=0), every data character is output one cycle later with outIsAddr=0, whatever addrMatch is.
- R9: In manual mode, an address character is output one cycle later with outIsAddr=1 and outData equal to its 8-bit address.
- R10: autoMode is sampled with each character, so a mode change applies from the next character onward. The match state set in one mode carries over into the other.
- R11: A cycle with rxValid=0 produces outValid=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| autoMode | input | 1 | 1 = hardware filtering, 0 = software filtering |
| nodeAddr | input | 8 | This node's address |
| rxValid | input | 1 | Received character strobe |
| rxChar | input | 9 | Received character; bit 8 is the address mark |
| outValid | output | 1 | Forwarded character valid |
| outData | output | 8 | Forwarded 8-bit payload |
| outIsAddr | output | 1 | Forwarded character was an address (manual mode only) |
| addrMatch | output | 1 | The most recent address equalled nodeAddr |
| addrSeen | output | 1 | One-cycle pulse per address character |

## Verification
The bench sends data with no prior address, then a non-matching address, then a matching address. This separates the closed filter from the open one and catches a filter that decides on the data byte rather than on the stored match. It sends a data byte equal to the node address, which shows whether the mark bit alone selects address handling. It switches modes between characters to confirm that the mode is sampled per character and that the match state carries across. It reprograms the node address to 0x00, which tests the comparison at the zero boundary. Back-to-back characters and idle gaps check that addrSeen lasts exactly one cycle and that idle cycles emit nothing.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  // strobes from control to datapath for one received character
  typedef struct packed {
    logic fwd;       // load output register and raise outValid
    logic markAddr;  // forwarded character is an address
  } ctrlStrobe_t;
endpackage

// File: rtl/mdf_datapath.sv
module mdf_datapath
  import mdf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W:0]   rxChar,
  input  logic [DATA_W-1:0] nodeAddr,
  input  ctrlStrobe_t       strobe,
  output logic              isAddrChar,
  output logic              isMatch,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outIsAddr
);
  localparam int MARK_BIT = DATA_W;

  assign isAddrChar = rxChar[MARK_BIT];
  assign isMatch    = (rxChar[DATA_W-1:0] == nodeAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outIsAddr <= 1'b0;
    end else begin
      outValid <= strobe.fwd;
      if (strobe.fwd) begin
        outData   <= rxChar[DATA_W-1:0];
        outIsAddr <= strobe.markAddr;
      end
    end
  end

  // R11 / R6 / R7: no forward strobe means no output next cycle
  p_no_spurious_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fwd |=> !outValid);
  // R5 / R8 / R9: forwarded payload equals the received low byte
  p_payload_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fwd |=> (outValid && outData == $past(rxChar[DATA_W-1:0])));
  // R9: address flag follows the mark bit of the forwarded character
  p_addr_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fwd |=> (outIsAddr == $past(rxChar[MARK_BIT])));
endmodule

// File: rtl/mdf_ctrl.sv
module mdf_ctrl
  import mdf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        isAddrChar,
  input  logic        isMatch,
  input  logic        autoMode,
  output ctrlStrobe_t strobe,
  output logic        addrMatch,
  output logic        addrSeen
);
  logic addrChar;
  logic dataChar;

  assign addrChar = rxValid & isAddrChar;
  assign dataChar = rxValid & ~isAddrChar;

  always_comb begin
    strobe          = '0;
    strobe.markAddr = addrChar;
    if (autoMode) strobe.fwd = dataChar & addrMatch;
    else          strobe.fwd = dataChar | addrChar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      addrSeen  <= 1'b0;
    end else begin
      addrSeen <= addrChar;
      if (addrChar) addrMatch <= isMatch;
    end
  end

  // R3: exactly one pulse per address character
  p_addr_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isAddrChar) |=> addrSeen);
  p_no_extra_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && isAddrChar) |=> !addrSeen);
  // R4 / R2: match state changes only on address characters
  p_match_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && isAddrChar) |=> $stable(addrMatch));
  // R6: closed filter in automatic mode forwards nothing
  p_auto_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !addrMatch) |-> !strobe.fwd);
  // R7: automatic mode never forwards address characters
  p_auto_no_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && rxValid && isAddrChar) |-> !strobe.fwd);
endmodule

// File: rtl/mdf_top.sv
module mdf_top
  import mdf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoMode,
  input  logic [7:0] nodeAddr,
  input  logic       rxValid,
  input  logic [8:0] rxChar,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outIsAddr,
  output logic       addrMatch,
  output logic       addrSeen
);
  ctrlStrobe_t strobe;
  logic        isAddrChar;
  logic        isMatch;

  mdf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .isAddrChar (isAddrChar),
    .isMatch    (isMatch),
    .autoMode   (autoMode),
    .strobe     (strobe),
    .addrMatch  (addrMatch),
    .addrSeen   (addrSeen)
  );

  mdf_datapath #(.DATA_W(8)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxChar     (rxChar),
    .nodeAddr   (nodeAddr),
    .strobe     (strobe),
    .isAddrChar (isAddrChar),
    .isMatch    (isMatch),
    .outValid   (outValid),
    .outData    (outData),
    .outIsAddr  (outIsAddr)
  );
endmodule

// File: tb/sim_mdf_top.sv
`timescale 1ns/1ps
module sim_mdf_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       autoMode = 1'b1;
  logic [7:0] nodeAddr = 8'h5A;
  logic       rxValid = 1'b0;
  logic [8:0] rxChar = '0;
  logic       outValid, outIsAddr, addrMatch, addrSeen;
  logic [7:0] outData;

  int vectors = 0;
  int fails = 0;
  logic mdlMatch = 1'b0;
  logic [8:0] expQ[$];
  bit done = 0;

  always #2 clk = ~clk;

  mdf_top u0 (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .nodeAddr(nodeAddr),
    .rxValid(rxValid), .rxChar(rxChar), .outValid(outValid), .outData(outData),
    .outIsAddr(outIsAddr), .addrMatch(addrMatch), .addrSeen(addrSeen)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected item on every output strobe
  always @(negedge clk) if (rstN && !done) begin
    if (outValid) begin
      if (expQ.size() == 0) check("R6/R7/R11 unexpected output", {outIsAddr, outData}, 9'h1FF);
      else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check("R5/R8/R9 forwarded character", {outIsAddr, outData}, e);
      end
    end
  end

  // driver: one character per cycle, then check flags after the edge
  task automatic sendChar(input logic mode, input logic [8:0] ch);
    @(negedge clk);
    autoMode = mode; rxValid = 1'b1; rxChar = ch;
    if (ch[8]) begin
      if (!mode) expQ.push_back(ch);
    end else if (!mode || mdlMatch) expQ.push_back(ch);
    if (ch[8]) mdlMatch = (ch[7:0] == nodeAddr);
    @(negedge clk);
    rxValid = 1'b0;
    check("R3 addrSeen pulse", {8'h0, addrSeen}, {8'h0, ch[8]});
    check("R4/R2 addrMatch", {8'h0, addrMatch}, {8'h0, mdlMatch});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0;
    end
    check("R3 no pulse when idle", {8'h0, addrSeen}, 9'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outValid", {8'h0, outValid}, 9'h0);
    check("R1 reset addrSeen", {8'h0, addrSeen}, 9'h0);
    check("R1 reset addrMatch", {8'h0, addrMatch}, 9'h0);
    rstN = 1'b1;
    idle(2);
    sendChar(1, 9'h011);           // R6: closed since reset
    sendChar(1, 9'h133);           // R7: non-matching address
    sendChar(1, 9'h022);           // R6
    sendChar(1, 9'h15A);           // R4: match
    sendChar(1, 9'h001);           // R5
    sendChar(1, 9'h0FF);           // R5 back-to-back
    sendChar(1, 9'h15A);           // R3 repeated matching address, R7
    sendChar(1, 9'h05A);           // R2: data equal to address, no match change
    idle(3);                       // R11
    sendChar(1, 9'h15B);           // R4: mismatch closes
    sendChar(1, 9'h0AA);           // R6
    sendChar(0, 9'h044);           // R8: manual forwards despite no match
    sendChar(0, 9'h177);           // R9: address forwarded with flag
    sendChar(1, 9'h055);           // R10: auto again, closed
    sendChar(0, 9'h15A);           // R10: match in manual, forwarded with flag
    sendChar(1, 9'h066);           // R10: carried match, auto forwards
    idle(2);
    nodeAddr = 8'h00;
    sendChar(1, 9'h100);           // R4: zero address matches
    sendChar(1, 9'h0C3);           // R5
    sendChar(1, 9'h101);           // R4 mismatch
    sendChar(0, 9'h000);           // R8
    idle(4);
    check("R5/R8/R9 all expected outputs seen", {1'b0, 8'(expQ.size())}, 9'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule